// File: doc/BRIEF.md
# ModR/M Effective Address Decoder

This block turns the addressing byte of a 32-bit x86-style instruction, plus any displacement bytes after it, into an effective address. Bytes arrive one per accepted transfer on a valid/ready byte stream. The first byte of each frame is the addressing byte. It holds a 2-bit mode, a 3-bit register/sub-operation field and a 3-bit base-register selector. The block reads the selected base register through a combinational read port on an eight-entry, 32-bit register file. It then takes zero, one or four displacement bytes, which arrive least significant byte first.

One cycle after the last byte a frame needs is accepted, the block pulses a done strobe. With the strobe it presents:
- the effective address,
- the register/sub-operation field,
- the number of bytes the frame consumed,
- one flag for a register-direct operand and one for a scaled-index escape, which this block does not support.

These results stay unchanged until the next done pulse. The decoder can then take the next addressing byte at once, so frames may follow each other back to back. It does not access memory and does not execute the opcode.

Top module: `ea_decoder`

## Requirements
- R1: On each done pulse, `reg_field_o` equals bits 5:3 of that frame's addressing byte.
- R2: Mode 00 with selector other than 4 or 5 consumes 1 byte: `ea_o` is the register selected by bits 2:0, and flags are 0.
- R3: Mode 00 with selector 5 uses no register: the next four bytes, least significant first, are `ea_o`; 5 bytes consumed.
- R4: Mode 01 takes one displacement byte, sign-extends it and adds it to the selected register (base 0x61 with 0xff gives 0x60); 2 bytes consumed. Selector 5 uses its register here.
- R5: Mode 10 takes four displacement bytes, least significant first, and adds them as a signed value to the selected register (ff ff ff ff subtracts one); 5 bytes consumed.
- R6: Mode 11 raises `direct_o` with `direct_idx_o` equal to bits 2:0, `ea_o` = 0, 1 byte consumed.
- R7: A mode other than 11 with selector 4 raises `sib_err_o`, `ea_o` = 0, 1 byte consumed, and the following byte is treated as a new addressing byte.
- R8: A byte counts only when `byte_valid_i` is high. `done_o` is high exactly in the cycle after the last needed byte is accepted and low otherwise. Idle cycles inside a frame do not change its result. `byte_ready_o` is high whenever out of reset.
- R9: Reset (active low `rst_ni`) clears `done_o`, `ea_o`, `consumed_o` and all flags, abandons a partial frame and waits for an addressing byte.
- R10: While waiting for an addressing byte, `rf_idx_o` follows bits 2:0 of `byte_data_i`, whether or not valid is high. Register index 0 is the accumulator, 3 is the base register and 4 is the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_valid_i | input | 1 | Byte on `byte_data_i` is offered |
| byte_data_i | input | 8 | Instruction byte stream |
| byte_ready_o | output | 1 | Decoder accepts a byte |
| rf_idx_o | output | 3 | Register file read index |
| rf_data_i | input | 32 | Register file read data for `rf_idx_o` |
| done_o | output | 1 | One-cycle result strobe |
| ea_o | output | 32 | Effective address |
| reg_field_o | output | 3 | Register/sub-operation field |
| consumed_o | output | 3 | Bytes consumed by the frame (1, 2 or 5) |
| direct_o | output | 1 | Operand is a register, not memory |
| direct_idx_o | output | 3 | Register index for a direct operand |
| sib_err_o | output | 1 | Unsupported scaled-index escape |

## Verification
The assertions assume that `rf_data_i` is a combinational function of `rf_idx_o` and settles within the cycle. They also assume that the first valid byte after reset is an addressing byte. The bench meets the first assumption with a fixed register-file array indexed by `rf_idx_o`. It meets the second by starting every frame with an addressing byte and re-entering from reset only at a frame start. The displacement lengths the bench sends are taken from the byte counts expected per requirement, so the stream never leaves the frame alignment the decoder assumes.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    MOD_IND = 2'b00,
    MOD_D8  = 2'b01,
    MOD_D32 = 2'b10,
    MOD_REG = 2'b11
  } mod_e;

  typedef enum logic [1:0] {
    EA_BASE,
    EA_ABS,
    EA_DIRECT,
    EA_SIB
  } ea_kind_e;

  localparam logic [2:0] RM_ESCAPE = 3'd4;
  localparam logic [2:0] RM_NOBASE = 3'd5;
endpackage

// File: rtl/modrm_split.sv
module modrm_split
  import ea_pkg::*;
#(
  parameter int DISP_BYTES = 4,
  parameter int LEN_W      = 3
) (
  input  logic [7:0]       modrm_i,
  output logic [2:0]       reg_o,
  output logic [2:0]       rm_o,
  output ea_kind_e         kind_o,
  output logic [LEN_W-1:0] disp_len_o
);
  mod_e mode;

  always_comb begin
    mode       = mod_e'(modrm_i[7:6]);
    reg_o      = modrm_i[5:3];
    rm_o       = modrm_i[2:0];
    kind_o     = EA_BASE;
    disp_len_o = '0;
    if (mode == MOD_REG) begin
      kind_o = EA_DIRECT;
    end else if (rm_o == RM_ESCAPE) begin
      kind_o = EA_SIB;
    end else if (mode == MOD_IND && rm_o == RM_NOBASE) begin
      kind_o     = EA_ABS;
      disp_len_o = LEN_W'(DISP_BYTES);
    end else if (mode == MOD_D8) begin
      disp_len_o = LEN_W'(1);
    end else if (mode == MOD_D32) begin
      disp_len_o = LEN_W'(DISP_BYTES);
    end
  end
endmodule

// File: rtl/disp_collect.sv
module disp_collect #(
  parameter int NBYTES = 4,
  parameter int CNT_W  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  take_i,
  input  logic [7:0]            byte_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [NBYTES*8-1:0]   disp_next_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       slot_q [NBYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (take_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_slot
    logic hit;
    assign hit = take_i && (cnt_q == CNT_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slot_q[i] <= '0;
      else if (clear_i) slot_q[i] <= '0;
      else if (hit)     slot_q[i] <= byte_i;
    end

    // little-endian: slot i lands in byte lane i, current byte merged in
    assign disp_next_o[i*8 +: 8] = hit ? byte_i : slot_q[i];
  end

  assign cnt_o = cnt_q;

  // R5: never more displacement bytes than a full word
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NBYTES));
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] disp_i,
  input  logic          use_base_i,
  input  logic          short_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] base_sel;
  logic [AW-1:0] disp_ext;

  always_comb begin
    base_sel = use_base_i ? base_i : '0;
    disp_ext = short_i ? {{(AW-8){disp_i[7]}}, disp_i[7:0]} : disp_i;
    sum_o    = base_sel + disp_ext;
  end
endmodule

// File: rtl/ea_decoder.sv
module ea_decoder
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic [2:0]        rf_idx_o,
  input  logic [ADDR_W-1:0] rf_data_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [2:0]        reg_field_o,
  output logic [2:0]        consumed_o,
  output logic              direct_o,
  output logic [2:0]        direct_idx_o,
  output logic              sib_err_o
);
  localparam int DISP_BYTES = ADDR_W / 8;
  localparam int LEN_W      = $clog2(DISP_BYTES + 2);

  typedef enum logic {S_MODRM, S_DISP} st_e;

  st_e              st_q;
  logic             in_modrm, accept, take, last_disp;
  logic [2:0]       f_reg, f_rm;
  ea_kind_e         f_kind;
  logic [LEN_W-1:0] f_len;

  logic [2:0]        reg_q, rm_q;
  ea_kind_e          kind_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  cnt;
  logic [ADDR_W-1:0] disp_next, sum;

  logic              done_q, direct_q, sib_q;
  logic [ADDR_W-1:0] ea_q;
  logic [2:0]        reg_field_q, idx_q;
  logic [LEN_W-1:0]  consumed_q;

  assign byte_ready_o = 1'b1;
  assign in_modrm     = (st_q == S_MODRM);
  assign accept       = byte_valid_i && byte_ready_o;
  assign take         = accept && !in_modrm;
  assign last_disp    = take && (cnt == len_q - LEN_W'(1));
  assign rf_idx_o     = in_modrm ? byte_data_i[2:0] : rm_q;

  modrm_split #(.DISP_BYTES(DISP_BYTES), .LEN_W(LEN_W)) u_split (
    .modrm_i    (byte_data_i),
    .reg_o      (f_reg),
    .rm_o       (f_rm),
    .kind_o     (f_kind),
    .disp_len_o (f_len)
  );

  disp_collect #(.NBYTES(DISP_BYTES), .CNT_W(LEN_W)) u_disp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept && in_modrm),
    .take_i      (take),
    .byte_i      (byte_data_i),
    .cnt_o       (cnt),
    .disp_next_o (disp_next)
  );

  ea_adder #(.AW(ADDR_W)) u_add (
    .base_i     (base_q),
    .disp_i     (disp_next),
    .use_base_i (kind_q == EA_BASE),
    .short_i    (len_q == LEN_W'(1)),
    .sum_o      (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_MODRM;
      reg_q       <= '0;
      rm_q        <= '0;
      kind_q      <= EA_BASE;
      len_q       <= '0;
      base_q      <= '0;
      done_q      <= 1'b0;
      ea_q        <= '0;
      reg_field_q <= '0;
      consumed_q  <= '0;
      direct_q    <= 1'b0;
      idx_q       <= '0;
      sib_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept && in_modrm) begin
        reg_q  <= f_reg;
        rm_q   <= f_rm;
        kind_q <= f_kind;
        len_q  <= f_len;
        base_q <= rf_data_i;
        if (f_len == '0) begin
          done_q      <= 1'b1;
          consumed_q  <= LEN_W'(1);
          reg_field_q <= f_reg;
          direct_q    <= (f_kind == EA_DIRECT);
          sib_q       <= (f_kind == EA_SIB);
          idx_q       <= (f_kind == EA_DIRECT) ? f_rm : 3'd0;
          ea_q        <= (f_kind == EA_BASE) ? rf_data_i : '0;
        end else begin
          st_q <= S_DISP;
        end
      end else if (last_disp) begin
        done_q      <= 1'b1;
        consumed_q  <= len_q + LEN_W'(1);
        reg_field_q <= reg_q;
        direct_q    <= 1'b0;
        sib_q       <= 1'b0;
        idx_q       <= '0;
        ea_q        <= sum;
        st_q        <= S_MODRM;
      end
    end
  end

  assign done_o       = done_q;
  assign ea_o         = ea_q;
  assign reg_field_o  = reg_field_q;
  assign consumed_o   = 3'(consumed_q);
  assign direct_o     = direct_q;
  assign direct_idx_o = idx_q;
  assign sib_err_o    = sib_q;

  a_r2_indirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_modrm && byte_data_i[7:6] == 2'b00 &&
     byte_data_i[2:0] != 3'd4 && byte_data_i[2:0] != 3'd5)
    |=> (done_o && consumed_o == 3'd1 && ea_o == $past(rf_data_i)));

  a_r6_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_modrm && byte_data_i[7:6] == 2'b11)
    |=> (done_o && direct_o && direct_idx_o == $past(byte_data_i[2:0]) && ea_o == '0));

  a_r7_escape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_modrm && byte_data_i[7:6] != 2'b11 && byte_data_i[2:0] == 3'd4)
    |=> (done_o && sib_err_o && consumed_o == 3'd1 && ea_o == '0));

  a_r8_no_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_modrm && !last_disp) |=> !done_o);

  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(direct_o && sib_err_o));

  a_r1_field_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(reg_field_o));
endmodule

// File: tb/ea_decoder_test.sv
`timescale 1ns/1ps
module ea_decoder_test;
  typedef struct packed {
    logic [7:0]  m;
    logic [31:0] d;
    logic [31:0] ea;
    logic [2:0]  n;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'h18, 32'h0,        32'h00000061, 3'd1},
    '{8'h03, 32'h0,        32'h00000010, 3'd1},
    '{8'h1d, 32'h00000060, 32'h00000060, 3'd5},
    '{8'h58, 32'h000000ff, 32'h00000060, 3'd2},
    '{8'h40, 32'h0000007f, 32'h000000e0, 3'd2},
    '{8'h5f, 32'h00000010, 32'h77770010, 3'd2},
    '{8'h98, 32'hffffffff, 32'h00000060, 3'd5},
    '{8'h9e, 32'h01020304, 32'h67680304, 3'd5},
    '{8'hd9, 32'h0,        32'h00000000, 3'd1},
    '{8'h04, 32'h0,        32'h00000000, 3'd1},
    '{8'h45, 32'h00000080, 32'h5554ff80, 3'd2},
    '{8'h85, 32'h00001000, 32'h55551000, 3'd5},
    '{8'h2c, 32'h0,        32'h00000000, 3'd1},
    '{8'he2, 32'h0,        32'h00000000, 3'd1}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h0;
  logic        byte_ready;
  logic [2:0]  rf_idx;
  logic [31:0] rf_data;
  logic        done;
  logic [31:0] ea;
  logic [2:0]  reg_field, consumed, direct_idx;
  logic        direct, sib_err;
  logic [31:0] rf [8];
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  assign rf_data = rf[rf_idx];

  ea_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_valid), .byte_data_i(byte_data),
    .byte_ready_o(byte_ready), .rf_idx_o(rf_idx), .rf_data_i(rf_data),
    .done_o(done), .ea_o(ea), .reg_field_o(reg_field), .consumed_o(consumed),
    .direct_o(direct), .direct_idx_o(direct_idx), .sib_err_o(sib_err)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  function automatic string tag_of(input logic [7:0] m);
    if (m[7:6] == 2'b11) return "R6";
    if (m[2:0] == 3'd4) return "R7";
    if (m[7:6] == 2'b00 && m[2:0] == 3'd5) return "R3";
    if (m[7:6] == 2'b00) return "R2";
    if (m[7:6] == 2'b01) return "R4";
    return "R5";
  endfunction

  task automatic run_vec(input vec_t v, input int gap);
    logic  exp_dir, exp_sib;
    string t;
    t       = tag_of(v.m);
    exp_dir = (v.m[7:6] == 2'b11);
    exp_sib = !exp_dir && (v.m[2:0] == 3'd4);
    put(v.m);
    for (int k = 1; k < int'(v.n); k++) begin
      chk(done == 1'b0, "R8", "done before last byte", 32'(done), 32'h0);
      repeat (gap) @(negedge clk);
      put(v.d[(k-1)*8 +: 8]);
    end
    chk(done == 1'b1, "R8", "done after last byte", 32'(done), 32'h1);
    chk(ea == v.ea, t, "ea", ea, v.ea);
    chk(consumed == v.n, t, "consumed", 32'(consumed), 32'(v.n));
    chk(reg_field == v.m[5:3], "R1", "reg field", 32'(reg_field), 32'(v.m[5:3]));
    chk(direct == exp_dir, "R6", "direct flag", 32'(direct), 32'(exp_dir));
    chk(direct_idx == (exp_dir ? v.m[2:0] : 3'd0), "R6", "direct idx",
        32'(direct_idx), 32'(exp_dir ? v.m[2:0] : 3'd0));
    chk(sib_err == exp_sib, "R7", "escape flag", 32'(sib_err), 32'(exp_sib));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rf[0] = 32'h00000061; rf[1] = 32'h11110000; rf[2] = 32'h22220000; rf[3] = 32'h00000010;
    rf[4] = 32'h44440000; rf[5] = 32'h55550000; rf[6] = 32'h66660000; rf[7] = 32'h77770000;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9", "done in reset", 32'(done), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ea == 32'h0 && consumed == 3'd0, "R9", "outputs after reset", ea, 32'h0);
    chk(byte_ready == 1'b1, "R8", "ready", 32'(byte_ready), 32'h1);

    // R10: read index follows the offered byte even without valid
    byte_data = 8'h03;
    #1 chk(rf_idx == 3'd3, "R10", "rf idx", 32'(rf_idx), 32'h3);
    byte_data = 8'h06;
    #1 chk(rf_idx == 3'd6, "R10", "rf idx", 32'(rf_idx), 32'h6);
    @(negedge clk);
    chk(done == 1'b0, "R8", "byte without valid ignored", 32'(done), 32'h0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], 0);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done one cycle only", 32'(done), 32'h0);
    end

    // R8: idle gaps inside a frame
    run_vec(VEC[7], 2);
    @(negedge clk);

    // R8: back-to-back frames
    put(8'h18);
    chk(done && ea == 32'h61, "R8", "b2b first", ea, 32'h61);
    put(8'h03);
    chk(done && ea == 32'h10, "R8", "b2b second", ea, 32'h10);

    // R7: byte after escape is a fresh addressing byte
    put(8'h04);
    put(8'h03);
    chk(done && ea == 32'h10 && !sib_err, "R7", "after escape", ea, 32'h10);
    @(negedge clk);

    // R9: reset mid-frame
    put(8'h98);
    put(8'h04);
    put(8'h03);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && ea == 32'h0, "R9", "mid-frame reset", ea, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    put(8'h18);
    chk(done && ea == 32'h61 && consumed == 3'd1, "R9", "restart at addressing byte", ea, 32'h61);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule